// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block is the host-side engine that modifies a serial NOR flash. A local client hands it one request at a time: an operation (page program, sector erase or whole-device erase), a 24-bit flash address and, for programming, a byte count, with the program data supplied on a separate valid/ready byte stream. The block screens the request, then talks to the flash over a mode-0 SPI link whose clock is a fixed division of the system clock. Each frame is bounded by chip select. Between frames chip select stays high for a programmable number of system clocks.

An accepted request always runs the same sequence. A one-byte write-enable frame comes first. The modifying frame follows: program carries an opcode, three address bytes and the data; sector erase carries an opcode and the address; bulk erase is a single opcode. The block then repeats a two-byte status-read frame until the busy bit in the returned status is clear, and finishes with a one-cycle done pulse. A program that would be empty, longer than a page, or run past the end of its 256-byte page is refused with an error and produces no SPI traffic. So is an undefined operation code. Status reads stop after a fixed number of busy answers, and the operation then ends with a timeout error.

The controller is one state machine. Its states are IDLE, GAP_WREN, WREN, GAP_CMD, CMD, ADDR, DATA, GAP_POLL, POLL_CMD, POLL_RD and DONE. Its transitions are:

- IDLE goes to DONE on a refused request and to GAP_WREN on an accepted one.
- GAP_WREN goes to WREN, and GAP_CMD goes to CMD, once the gap count is reached.
- WREN goes to GAP_CMD when its byte completes.
- CMD goes to GAP_POLL for bulk erase and to ADDR otherwise.
- ADDR goes to DATA for program, or to GAP_POLL for sector erase, after the third address byte.
- DATA goes to GAP_POLL after the last data byte.
- GAP_POLL goes to POLL_CMD once the gap count is reached.
- POLL_CMD goes to POLL_RD when the opcode byte completes.
- POLL_RD goes to DONE when the busy bit is clear or the poll limit is reached, and back to GAP_POLL otherwise.
- DONE goes to IDLE.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset the block is idle: `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `done` and `wr_ready` are 0.
- R2: A request is refused, with `done` and `err_reject` both high for one cycle and chip select never asserted, when `req_op` is 3, or when `req_op` is 0 (program) and `req_len` is 0, `req_len` exceeds 256, or the low address byte plus `req_len` exceeds 256. For erase operations `req_len` is ignored.
- R3: Every accepted request first sends a frame consisting of the single byte 06h.
- R4: A program request (`req_op` = 0) next sends one frame: 02h, then the address bytes from most to least significant, then exactly `req_len` bytes taken from the write stream in arrival order.
- R5: A sector erase (`req_op` = 1) next sends the frame D8h followed by the three address bytes, most significant first. A bulk erase (`req_op` = 2) next sends the single-byte frame C7h.
- R6: After the modifying frame, the block repeats frames of 05h followed by one dummy byte 00h. It stops after the first status byte whose bit 0 is 0, and then pulses `done` for exactly one cycle with no error flag.
- R7: If POLL_MAX consecutive status bytes have bit 0 set, the block sends no further frame and pulses `done` together with `err_timeout`.
- R8: Chip select stays high for at least GAP_CYC system clocks before every falling edge.
- R9: SPI runs in mode 0. `spi_sck` is low whenever chip select is high. Each clock phase lasts CLK_DIV system clocks. Bytes go out most significant bit first, and `spi_mosi` never changes while `spi_sck` is high.
- R10: `req_ready` is low from acceptance until after `done`, and requests presented meanwhile are ignored. `wr_ready` is high only while a data byte is awaited inside a program frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 refused |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Program byte count, 1 to 256 |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte consumed when high with wr_valid |
| done | output | 1 | One-cycle completion pulse |
| err_reject | output | 1 | With done: request refused |
| err_timeout | output | 1 | With done: busy bit never cleared |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The bench builds the block with CLK_DIV = 2, GAP_CYC = 3 and POLL_MAX = 4. The page size stays at 256 bytes, so a full-page program and a program ending exactly on the page's last byte are both exercised. Three gap clocks make the inter-frame check stricter than the bare minimum. A poll limit of four lets a flash model that stays busy drive the timeout path within a few hundred cycles. The same model, answering busy for a chosen number of status reads, covers poll counts from one up to the limit.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_SECT = 8'hD8;
    localparam logic [7:0] OPC_BULK = 8'hC7;
    localparam logic [7:0] OPC_RDSR = 8'h05;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BULK = 2'd2,
        OP_NONE = 2'd3
    } fseq_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GAP_WREN,
        S_WREN,
        S_GAP_CMD,
        S_CMD,
        S_ADDR,
        S_DATA,
        S_GAP_POLL,
        S_POLL_CMD,
        S_POLL_RD,
        S_DONE
    } fseq_state_e;

endpackage

// File: rtl/fseq_spi_byte.sv
module fseq_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    shreg   <= tx_byte;
                    mosi    <= tx_byte[7];
                    sck     <= 1'b0;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck     <= 1'b0;
                    rx_byte <= {rx_byte[6:0], miso};
                    if (bit_cnt == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        shreg   <= {shreg[6:0], 1'b0};
                        mosi    <= shreg[6];
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/fseq_req_check.sv
module fseq_req_check #(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24
) (
    input  logic [1:0]                    op,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [$clog2(PAGE_BYTES):0]   len,
    output logic                          reject
);
    import fseq_pkg::*;

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int LEN_W = OFF_W + 1;
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] end_pos;
    logic             bad_len;

    always_comb begin
        end_pos = SUM_W'(addr[OFF_W-1:0]) + SUM_W'(len);
        bad_len = (len == '0) || (len > LEN_W'(PAGE_BYTES))
                  || (end_pos > SUM_W'(PAGE_BYTES));
        unique case (op)
            OP_PROG: reject = bad_len;
            OP_SECT: reject = 1'b0;
            OP_BULK: reject = 1'b0;
            default: reject = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq #(
    parameter int CLK_DIV    = 2,
    parameter int GAP_CYC    = 2,
    parameter int POLL_MAX   = 100000,
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_op,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [$clog2(PAGE_BYTES):0] req_len,
    input  logic [7:0]                  wr_data,
    input  logic                        wr_valid,
    output logic                        wr_ready,
    output logic                        done,
    output logic                        err_reject,
    output logic                        err_timeout,
    output logic                        spi_cs_n,
    output logic                        spi_sck,
    output logic                        spi_mosi,
    input  logic                        spi_miso
);
    import fseq_pkg::*;

    localparam int LEN_W      = $clog2(PAGE_BYTES) + 1;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int POLL_W     = $clog2(POLL_MAX + 1);
    localparam int GAP_W      = $clog2(GAP_CYC + 1);

    fseq_state_e state, state_nx;

    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              inflight;
    logic              rej_q;
    logic              tmo_q;

    logic              reject;
    logic              eng_start;
    logic [7:0]        eng_tx;
    logic              eng_busy;
    logic              eng_done;
    logic [7:0]        eng_rx;
    logic              gap_end;
    logic              poll_last;
    logic              accept;
    logic [7:0]        addr_byte;

    fseq_req_check #(
        .PAGE_BYTES(PAGE_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_check (
        .op    (req_op),
        .addr  (req_addr),
        .len   (req_len),
        .reject(reject)
    );

    fseq_spi_byte #(
        .CLK_DIV(CLK_DIV)
    ) u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .tx_byte(eng_tx),
        .busy   (eng_busy),
        .done   (eng_done),
        .rx_byte(eng_rx),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .miso   (spi_miso)
    );

    assign accept    = (state == S_IDLE) && req_valid;
    assign gap_end   = (gap_cnt == GAP_W'(GAP_CYC - 1));
    assign poll_last = (poll_cnt == POLL_W'(POLL_MAX - 1));

    always_comb begin
        addr_byte = 8'(addr_q >> (8 * (ADDR_BYTES - 1 - int'(cnt))));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = reject ? S_DONE : S_GAP_WREN;
            S_GAP_WREN: if (gap_end) state_nx = S_WREN;
            S_WREN:     if (eng_done) state_nx = S_GAP_CMD;
            S_GAP_CMD:  if (gap_end) state_nx = S_CMD;
            S_CMD:      if (eng_done) state_nx = (op_q == OP_BULK) ? S_GAP_POLL : S_ADDR;
            S_ADDR:     if (eng_done && cnt == LEN_W'(ADDR_BYTES - 1))
                            state_nx = (op_q == OP_PROG) ? S_DATA : S_GAP_POLL;
            S_DATA:     if (eng_done && cnt == len_q - LEN_W'(1)) state_nx = S_GAP_POLL;
            S_GAP_POLL: if (gap_end) state_nx = S_POLL_CMD;
            S_POLL_CMD: if (eng_done) state_nx = S_POLL_RD;
            S_POLL_RD:  if (eng_done) begin
                            if (!eng_rx[0] || poll_last) state_nx = S_DONE;
                            else                         state_nx = S_GAP_POLL;
                        end
            S_DONE:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        wr_ready    = 1'b0;
        done        = 1'b0;
        err_reject  = 1'b0;
        err_timeout = 1'b0;
        spi_cs_n    = 1'b0;
        eng_start   = 1'b0;
        eng_tx      = 8'h00;
        unique case (state)
            S_IDLE: begin
                req_ready = 1'b1;
                spi_cs_n  = 1'b1;
            end
            S_GAP_WREN, S_GAP_CMD, S_GAP_POLL: spi_cs_n = 1'b1;
            S_WREN: begin
                eng_start = !inflight;
                eng_tx    = OPC_WREN;
            end
            S_CMD: begin
                eng_start = !inflight;
                unique case (op_q)
                    OP_PROG: eng_tx = OPC_PROG;
                    OP_SECT: eng_tx = OPC_SECT;
                    default: eng_tx = OPC_BULK;
                endcase
            end
            S_ADDR: begin
                eng_start = !inflight;
                eng_tx    = addr_byte;
            end
            S_DATA: begin
                wr_ready  = !inflight;
                eng_start = !inflight && wr_valid;
                eng_tx    = wr_data;
            end
            S_POLL_CMD: begin
                eng_start = !inflight;
                eng_tx    = OPC_RDSR;
            end
            S_POLL_RD: begin
                eng_start = !inflight;
                eng_tx    = 8'h00;
            end
            S_DONE: begin
                spi_cs_n    = 1'b1;
                done        = 1'b1;
                err_reject  = rej_q;
                err_timeout = tmo_q;
            end
            default: spi_cs_n = 1'b1;
        endcase
    end

    // Request capture, counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            addr_q   <= '0;
            len_q    <= '0;
            cnt      <= '0;
            poll_cnt <= '0;
            gap_cnt  <= '0;
            inflight <= 1'b0;
            rej_q    <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            if (accept) begin
                op_q     <= req_op;
                addr_q   <= req_addr;
                len_q    <= req_len;
                cnt      <= '0;
                poll_cnt <= '0;
                rej_q    <= reject;
                tmo_q    <= 1'b0;
            end

            if (state == S_GAP_WREN || state == S_GAP_CMD || state == S_GAP_POLL)
                gap_cnt <= gap_end ? '0 : gap_cnt + GAP_W'(1);
            else
                gap_cnt <= '0;

            if (eng_start)     inflight <= 1'b1;
            else if (eng_done) inflight <= 1'b0;

            if (eng_done) begin
                if (state == S_ADDR)
                    cnt <= (cnt == LEN_W'(ADDR_BYTES - 1)) ? '0 : cnt + LEN_W'(1);
                else if (state == S_DATA)
                    cnt <= (cnt == len_q - LEN_W'(1)) ? '0 : cnt + LEN_W'(1);
                if (state == S_POLL_RD && eng_rx[0]) begin
                    poll_cnt <= poll_cnt + POLL_W'(1);
                    if (poll_last) tmo_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
    parameter int GAP_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic wr_ready,
    input logic done,
    input logic err_reject,
    input logic err_timeout,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);

    logic [15:0] hi_cnt;
    logic        cs_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            cs_act <= 1'b0;
        end else begin
            if (spi_cs_n) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
            else          hi_cnt <= '0;
            if (req_valid && req_ready) cs_act <= 1'b0;
            else if (!spi_cs_n)         cs_act <= 1'b1;
        end
    end

    a_r9_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r9_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (int'(hi_cnt) >= GAP_CYC));

    a_r10_wr_ready_framed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!spi_cs_n && !req_ready));

    a_r10_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err_reject |-> (done && !cs_act));

    a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (done && !err_reject));

endmodule

bind flash_wr_seq fseq_checker #(
    .GAP_CYC(GAP_CYC)
) u_fseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .wr_ready   (wr_ready),
    .done       (done),
    .err_reject (err_reject),
    .err_timeout(err_timeout),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi)
);

// File: tb/test_flash_wr_seq.sv
`timescale 1ns/1ps
module test_flash_wr_seq;

    localparam int CLK_DIV  = 2;
    localparam int GAP_CYC  = 3;
    localparam int POLL_MAX = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [8:0]  req_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic        done;
    logic        err_reject;
    logic        err_timeout;
    logic        spi_cs_n;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    flash_wr_seq #(
        .CLK_DIV (CLK_DIV),
        .GAP_CYC (GAP_CYC),
        .POLL_MAX(POLL_MAX)
    ) i_flash_wr_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .done(done), .err_reject(err_reject), .err_timeout(err_timeout),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input bit first, input logic [7:0] b, input string tag);
        exp_q.push_back({first, b});
        tag_q.push_back(tag);
    endtask

    // Flash model and scoreboard monitor
    int         frames = 0;
    int         bitn = 0;
    int         byte_idx = 0;
    logic [7:0] rx_sr = '0;
    bit         stat_pending = 0;
    int         rd_cnt = 0;
    logic [7:0] rd_sh = '0;
    int         busy_left = 0;

    always @(negedge spi_cs_n) begin
        frames++;
        bitn = 0;
        byte_idx = 0;
    end

    always @(posedge spi_sck) begin
        rx_sr = {rx_sr[6:0], spi_mosi};
        bitn++;
        if (bitn == 8) begin
            logic [8:0] got;
            got = {byte_idx == 0, rx_sr};
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected SPI byte", int'(got), 0);
            end else begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got == e, t, int'(got), int'(e));
            end
            if (byte_idx == 0 && rx_sr == 8'h05) stat_pending = 1;
            byte_idx++;
            bitn = 0;
        end
    end

    always @(negedge spi_sck) begin
        if (stat_pending) begin
            rd_sh = (busy_left > 0) ? 8'h01 : 8'h00;
            if (busy_left > 0) busy_left--;
            spi_miso = rd_sh[7];
            rd_sh = {rd_sh[6:0], 1'b0};
            stat_pending = 0;
            rd_cnt = 7;
        end else if (rd_cnt > 0) begin
            spi_miso = rd_sh[7];
            rd_sh = {rd_sh[6:0], 1'b0};
            rd_cnt--;
        end
    end

    // Timing monitor: chip-select gap and SCK phase widths
    int hi_cs = 0;
    int sck_hi = 0;
    int sck_lo = 0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (spi_cs_n) hi_cs++;
            else begin
                if (hi_cs > 0) chk(hi_cs >= GAP_CYC, "R8 cs high gap", hi_cs, GAP_CYC);
                hi_cs = 0;
            end
            if (spi_cs_n && spi_sck) chk(0, "R9 sck high with cs high", 1, 0);
            if (spi_sck) begin
                sck_hi++;
                if (sck_lo > 0 && !spi_cs_n && sck_lo < CLK_DIV)
                    chk(0, "R9 sck low phase", sck_lo, CLK_DIV);
                sck_lo = 0;
            end else begin
                if (sck_hi > 0) chk(sck_hi == CLK_DIV, "R9 sck high phase", sck_hi, CLK_DIV);
                sck_hi = 0;
                if (!spi_cs_n) sck_lo++;
                else sck_lo = 0;
            end
        end
    end

    function automatic logic [7:0] dbyte(input logic [23:0] a, input int i);
        return 8'(a + 24'(i * 7) + 24'd3);
    endfunction

    task automatic feed(input int n, input logic [23:0] a);
        int  i = 0;
        bit  stalled = 0;
        while (i < n || wr_valid) begin
            @(negedge clk);
            if (wr_valid) begin
                i++;
                wr_valid = 1'b0;
            end
            if (i < n && wr_ready) begin
                if (i % 3 == 1 && !stalled) stalled = 1;
                else begin
                    stalled  = 0;
                    wr_data  = dbyte(a, i);
                    wr_valid = 1'b1;
                end
            end
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input int len,
                          input int busy, input bit exp_rej, input bit exp_tmo,
                          input bit spur, input string tag);
        int  f0;
        int  npoll;
        int  exp_frames;
        bit  seen = 0;
        f0 = frames;
        busy_left = busy;
        if (!exp_rej) begin
            push(1, 8'h06, "R3 write-enable frame");
            case (op)
                2'd0: push(1, 8'h02, "R4 program opcode");
                2'd1: push(1, 8'hD8, "R5 sector opcode");
                default: push(1, 8'hC7, "R5 bulk opcode");
            endcase
            if (op != 2'd2) begin
                push(0, a[23:16], "R4 R5 address hi");
                push(0, a[15:8],  "R4 R5 address mid");
                push(0, a[7:0],   "R4 R5 address lo");
            end
            if (op == 2'd0)
                for (int i = 0; i < len; i++) push(0, dbyte(a, i), "R4 data byte");
            npoll = exp_tmo ? POLL_MAX : busy + 1;
            for (int p = 0; p < npoll; p++) begin
                push(1, 8'h05, "R6 status opcode");
                push(0, 8'h00, "R6 status dummy");
            end
            exp_frames = 2 + npoll;
        end else begin
            exp_frames = 0;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R10 ready before request"}, int'(req_ready), 1);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_len   = 9'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0 || done, {tag, " R10 ready low after accept"}, int'(req_ready), 0);
        fork
            if (op == 2'd0 && !exp_rej) feed(len, a);
            if (spur) begin
                repeat (30) @(negedge clk);
                req_valid = 1'b1;
                req_op    = 2'd0;
                req_addr  = 24'h000010;
                req_len   = 9'd1;
                repeat (3) @(negedge clk);
                req_valid = 1'b0;
            end
            begin
                for (int w = 0; w < 20000 && !seen; w++) begin
                    if (done) begin
                        seen = 1;
                        chk(err_reject == exp_rej, {tag, " R2 reject flag"}, int'(err_reject), int'(exp_rej));
                        chk(err_timeout == exp_tmo, {tag, " R7 timeout flag"}, int'(err_timeout), int'(exp_tmo));
                    end else @(negedge clk);
                end
                chk(seen, {tag, " R6 done seen"}, int'(seen), 1);
                @(negedge clk);
                chk(done == 1'b0, {tag, " R6 done single pulse"}, int'(done), 0);
                chk(req_ready == 1'b1, {tag, " R10 ready after done"}, int'(req_ready), 1);
            end
        join
        repeat (40) @(negedge clk);
        chk(frames - f0 == exp_frames, {tag, " R7 frame count"}, frames - f0, exp_frames);
        chk(exp_q.size() == 0, {tag, " R6 bytes outstanding"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        busy_left = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n after reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 sck after reset", int'(spi_sck), 0);
        chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
        chk(done == 1'b0 && wr_ready == 1'b0, "R1 done/wr_ready after reset",
            int'({done, wr_ready}), 0);

        run_op(2'd0, 24'h012300, 4,   2, 0, 0, 0, "R4 program short");
        run_op(2'd0, 24'h004500, 256, 0, 0, 0, 0, "R4 program full page");
        run_op(2'd0, 24'h0000FC, 4,   1, 0, 0, 0, "R2 program to page end");
        run_op(2'd0, 24'h0000FD, 4,   0, 1, 0, 0, "R2 page cross");
        run_op(2'd0, 24'h000000, 0,   0, 1, 0, 0, "R2 zero length");
        run_op(2'd0, 24'h000000, 257, 0, 1, 0, 0, "R2 over length");
        run_op(2'd3, 24'h000000, 1,   0, 1, 0, 0, "R2 undefined op");
        run_op(2'd1, 24'hABCDEF, 0,   3, 0, 0, 0, "R5 sector erase");
        run_op(2'd2, 24'h000000, 0,   1, 0, 0, 1, "R5 R10 bulk erase");
        run_op(2'd0, 24'h3F0010, 3,  10, 0, 1, 0, "R7 timeout");
        run_op(2'd1, 24'h100000, 0,   0, 0, 0, 0, "R6 erase ready at once");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", cycles, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule